// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits on the host side of an asynchronous NOR-type flash bus. It accepts one request at a time over a valid/ready command port: program a word, erase a sector, or erase the whole chip. It then plays out the unlock and command write cycles on the flash pins. Chip select, write strobe and read strobe are all timed in whole clock cycles. After the last write it reads status words from the target address. It treats the operation as finished once two reads in a row return the same value on data bit 6. A program gets one extra read, which compares the stored word against the data that was written. The block then pulses a done flag, together with an error flag or a timeout flag when needed.

The command port follows plain valid/ready rules. A request is taken on any rising clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from that edge until the cycle in which `op_done` pulses. A requester may keep `cmd_valid` high with the next request while it waits. The request fields are sampled only at the accepting edge. All strobe widths, setup times and timeout limits are parameters counted in clock cycles.

Top module: `flash_op_seq`

## Requirements
- R1: Op code 2'b00 (program) produces exactly four write cycles, in this order: AAh at 555h, 55h at 2AAh, A0h at 555h, then the request data at the request address.
- R2: Op code 2'b01 (sector erase) produces exactly six write cycles, in this order: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 30h at the request address.
- R3: Op code 2'b10 or 2'b11 (chip erase) produces the same first five writes as R2, followed by a sixth write of 10h at 555h.
- R4: During every write cycle the block drives chip select low for `T_AS` cycles before the write strobe falls. It holds the write strobe low for exactly `T_WP` cycles. Address and data stay stable while the strobe is low and across its rising edge. Between two write pulses the strobe stays high for at least `T_WPH` cycles.
- R5: Each status or verify read drives the request address and chip select for `T_ASO` cycles before the read strobe falls. The read strobe then stays low for `T_RD` cycles. The write strobe and read strobe are never low together.
- R6: Polling ends at the first read whose bit 6 equals bit 6 of the read just before it. Every read before that counts as busy.
- R7: After a program completes, one further read is made. `op_err` pulses with `op_done` if that word differs from the request data. An erase makes no such read and never raises `op_err`.
- R8: If polling has run for at least the op's timeout limit (`TMO_PROG`, `TMO_SERASE` or `TMO_CERASE` cycles) and the next read still shows a toggle, `op_done` pulses with `op_timeout`. This never happens before the limit has elapsed.
- R9: `cmd_ready` is high only while no operation is in progress. It falls at the accepting edge and returns high in the cycle `op_done` pulses. Requests offered in between are not taken.
- R10: While reset is low, and right after it is asserted even in the middle of an operation, all strobes are high, the data bus is not driven, `cmd_ready` is high and the status outputs are low.
- R11: `fl_dq_oe` is high only during write cycles and is never high while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Request offered |
| cmd_ready | output | 1 | Sequencer idle and able to take a request |
| cmd_op | input | 2 | 00 program, 01 sector erase, 1x chip erase |
| cmd_addr | input | AW | Word address for the program or sector |
| cmd_data | input | DW | Word to program |
| op_done | output | 1 | One-cycle pulse when an operation ends |
| op_err | output | 1 | With op_done: verify mismatch |
| op_timeout | output | 1 | With op_done: timeout limit exceeded |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | DW | Write data toward the flash |
| fl_dq_in | input | DW | Read data from the flash |
| fl_dq_oe | output | 1 | Data bus driver enable |
| fl_cs_n | output | 1 | Chip select, active low |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_oe_n | output | 1 | Read strobe, active low |

## Verification
The bench feeds the sequencer a flash model whose bit 6 toggles for a set number of reads and then settles on a stored word. It checks the count of polling reads against what R6 predicts. This exposes three faults: a design that stops after a single read, one that always takes a fixed number of reads, and one that misses the case where the last toggling value happens to match the settled word. It covers a device that finishes at once with zero busy reads. It also runs an erase whose stored word differs from the request data, where a design that verified erases would flag a false error. Timeout runs check that the flag is never raised before the limit has passed. A reset in the middle of a program and a `cmd_valid` held high through an operation show whether a design leaves strobes low or accepts a second request early.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_POLL, ST_VERIFY} seq_state_e;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_RECOV} bus_phase_e;

  localparam logic [1:0]  OPC_PROG   = 2'b00;
  localparam logic [1:0]  OPC_SERASE = 2'b01;
  localparam logic [11:0] UNLK_A     = 12'h555;
  localparam logic [11:0] UNLK_B     = 12'h2AA;

  // one entry of a command sequence; at_target selects the request address
  typedef struct packed {
    logic        at_target;
    logic [11:0] uaddr;
    logic [7:0]  code;
  } bus_word_t;

  function automatic logic [2:0] last_step(input logic [1:0] op);
    return (op == OPC_PROG) ? 3'd3 : 3'd5;
  endfunction

  function automatic bus_word_t step_word(input logic [1:0] op, input logic [2:0] step);
    bus_word_t w;
    w.at_target = 1'b0;
    w.uaddr     = UNLK_A;
    w.code      = 8'hAA;
    case (step)
      3'd0: ;
      3'd1: begin w.uaddr = UNLK_B; w.code = 8'h55; end
      3'd2: w.code = (op == OPC_PROG) ? 8'hA0 : 8'h80;
      3'd3: if (op == OPC_PROG) begin w.at_target = 1'b1; w.code = 8'h00; end
      3'd4: begin w.uaddr = UNLK_B; w.code = 8'h55; end
      default: begin
        if (op == OPC_SERASE) begin w.at_target = 1'b1; w.code = 8'h30; end
        else w.code = 8'h10;
      end
    endcase
    return w;
  endfunction

endpackage

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
  import flash_seq_pkg::*;
#(
  parameter int AW    = 21,
  parameter int DW    = 16,
  parameter int T_AS  = 1,
  parameter int T_WP  = 2,
  parameter int T_WPH = 2,
  parameter int T_ASO = 1,
  parameter int T_RD  = 5,
  parameter int T_OEH = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_read,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          cyc_done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_out,
  input  logic [DW-1:0] fl_dq_in,
  output logic          fl_dq_oe,
  output logic          fl_cs_n,
  output logic          fl_we_n,
  output logic          fl_oe_n
);

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int TMAX = imax(imax(imax(T_AS, T_WP), imax(T_WPH, T_ASO)), imax(T_RD, T_OEH));
  localparam int CW   = $clog2(TMAX + 1);

  bus_phase_e    phase;
  logic [CW-1:0] cnt;
  logic          rd_q;

  // every pin is a register so the asynchronous bus sees no decode glitches
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      rd_q      <= 1'b0;
      cyc_done  <= 1'b0;
      rdata     <= '0;
      fl_addr   <= '0;
      fl_dq_out <= '0;
      fl_dq_oe  <= 1'b0;
      fl_cs_n   <= 1'b1;
      fl_we_n   <= 1'b1;
      fl_oe_n   <= 1'b1;
    end else begin
      cyc_done <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase     <= PH_SETUP;
            rd_q      <= is_read;
            cnt       <= is_read ? CW'(T_ASO - 1) : CW'(T_AS - 1);
            fl_addr   <= addr;
            fl_dq_out <= wdata;
            fl_dq_oe  <= !is_read;
            fl_cs_n   <= 1'b0;
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            phase   <= PH_STROBE;
            cnt     <= rd_q ? CW'(T_RD - 1) : CW'(T_WP - 1);
            fl_we_n <= rd_q;
            fl_oe_n <= !rd_q;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_STROBE: begin
          if (cnt == '0) begin
            phase   <= PH_RECOV;
            cnt     <= rd_q ? CW'(T_OEH - 1) : CW'(T_WPH - 1);
            fl_we_n <= 1'b1;
            fl_oe_n <= 1'b1;
            fl_cs_n <= 1'b1;
            if (rd_q) rdata <= fl_dq_in;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) begin
            phase    <= PH_IDLE;
            fl_dq_oe <= 1'b0;
            cyc_done <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expired
);

  logic [TW-1:0] cnt;

  assign expired = (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
  import flash_seq_pkg::*;
#(
  parameter int AW         = 21,
  parameter int DW         = 16,
  parameter int T_AS       = 1,
  parameter int T_WP       = 2,
  parameter int T_WPH      = 2,
  parameter int T_ASO      = 1,
  parameter int T_RD       = 5,
  parameter int T_OEH      = 1,
  parameter int TMO_PROG   = 15000,
  parameter int TMO_SERASE = 250000000,
  parameter int TMO_CERASE = 2100000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  output logic          op_done,
  output logic          op_err,
  output logic          op_timeout,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_out,
  input  logic [DW-1:0] fl_dq_in,
  output logic          fl_dq_oe,
  output logic          fl_cs_n,
  output logic          fl_we_n,
  output logic          fl_oe_n
);

  localparam int TMO_A = (TMO_PROG > TMO_SERASE) ? TMO_PROG : TMO_SERASE;
  localparam int TMO_M = (TMO_A > TMO_CERASE) ? TMO_A : TMO_CERASE;
  localparam int TW    = $clog2(TMO_M + 1);
  localparam int SB    = 6;  // toggle bit position

  seq_state_e    state;
  logic [1:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [2:0]    step;
  logic          launch;
  logic          have_prev;
  logic          prev_tb;

  logic          issue, issue_rd;
  logic [AW-1:0] issue_addr;
  logic [DW-1:0] issue_data;
  logic          bus_done;
  logic [DW-1:0] bus_rdata;

  logic          tmr_expired;
  logic [TW-1:0] tmr_limit;

  bus_word_t     sw;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  always_comb begin
    sw      = step_word(op_q, step);
    wr_addr = sw.at_target ? addr_q : AW'(sw.uaddr);
    wr_data = (sw.at_target && op_q == OPC_PROG) ? data_q : DW'(sw.code);
  end

  always_comb begin
    if (op_q == OPC_PROG)        tmr_limit = TW'(TMO_PROG);
    else if (op_q == OPC_SERASE) tmr_limit = TW'(TMO_SERASE);
    else                         tmr_limit = TW'(TMO_CERASE);
  end

  assign cmd_ready = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      op_q       <= '0;
      addr_q     <= '0;
      data_q     <= '0;
      step       <= '0;
      launch     <= 1'b0;
      have_prev  <= 1'b0;
      prev_tb    <= 1'b0;
      issue      <= 1'b0;
      issue_rd   <= 1'b0;
      issue_addr <= '0;
      issue_data <= '0;
      op_done    <= 1'b0;
      op_err     <= 1'b0;
      op_timeout <= 1'b0;
    end else begin
      issue      <= 1'b0;
      op_done    <= 1'b0;
      op_err     <= 1'b0;
      op_timeout <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            op_q   <= cmd_op;
            addr_q <= cmd_addr;
            data_q <= cmd_data;
            step   <= '0;
            launch <= 1'b1;
            state  <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (launch) begin
            issue      <= 1'b1;
            issue_rd   <= 1'b0;
            issue_addr <= wr_addr;
            issue_data <= wr_data;
            launch     <= 1'b0;
          end else if (bus_done) begin
            launch <= 1'b1;
            if (step == last_step(op_q)) begin
              state     <= ST_POLL;
              have_prev <= 1'b0;
            end else begin
              step <= step + 1'b1;
            end
          end
        end
        ST_POLL: begin
          if (launch) begin
            issue      <= 1'b1;
            issue_rd   <= 1'b1;
            issue_addr <= addr_q;
            launch     <= 1'b0;
          end else if (bus_done) begin
            if (have_prev && bus_rdata[SB] == prev_tb) begin
              if (op_q == OPC_PROG) begin
                state  <= ST_VERIFY;
                launch <= 1'b1;
              end else begin
                state   <= ST_IDLE;
                op_done <= 1'b1;
              end
            end else if (tmr_expired) begin
              state      <= ST_IDLE;
              op_done    <= 1'b1;
              op_timeout <= 1'b1;
            end else begin
              prev_tb   <= bus_rdata[SB];
              have_prev <= 1'b1;
              launch    <= 1'b1;
            end
          end
        end
        default: begin
          if (launch) begin
            issue      <= 1'b1;
            issue_rd   <= 1'b1;
            issue_addr <= addr_q;
            launch     <= 1'b0;
          end else if (bus_done) begin
            state   <= ST_IDLE;
            op_done <= 1'b1;
            op_err  <= (bus_rdata != data_q);
          end
        end
      endcase
    end
  end

  flash_busy_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (state == ST_POLL),
    .limit   (tmr_limit),
    .expired (tmr_expired)
  );

  flash_bus_cycle #(
    .AW(AW), .DW(DW), .T_AS(T_AS), .T_WP(T_WP), .T_WPH(T_WPH),
    .T_ASO(T_ASO), .T_RD(T_RD), .T_OEH(T_OEH)
  ) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (issue),
    .is_read   (issue_rd),
    .addr      (issue_addr),
    .wdata     (issue_data),
    .cyc_done  (bus_done),
    .rdata     (bus_rdata),
    .fl_addr   (fl_addr),
    .fl_dq_out (fl_dq_out),
    .fl_dq_in  (fl_dq_in),
    .fl_dq_oe  (fl_dq_oe),
    .fl_cs_n   (fl_cs_n),
    .fl_we_n   (fl_we_n),
    .fl_oe_n   (fl_oe_n)
  );

endmodule

// File: rtl/flash_op_seq_chk.sv
module flash_op_seq_chk #(
  parameter int AW    = 21,
  parameter int DW    = 16,
  parameter int T_WP  = 2,
  parameter int T_WPH = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          op_done,
  input logic          op_err,
  input logic          op_timeout,
  input logic [AW-1:0] fl_addr,
  input logic [DW-1:0] fl_dq_out,
  input logic          fl_dq_oe,
  input logic          fl_cs_n,
  input logic          fl_we_n,
  input logic          fl_oe_n
);

  logic [15:0] low_cnt, high_cnt;
  logic        seen_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt   <= '0;
      high_cnt  <= '0;
      seen_rise <= 1'b0;
    end else begin
      if (!fl_we_n) low_cnt <= (low_cnt != '1) ? low_cnt + 1'b1 : low_cnt;
      else          low_cnt <= '0;
      if (!fl_we_n) high_cnt <= '0;
      else          high_cnt <= (high_cnt != '1) ? high_cnt + 1'b1 : high_cnt;
      if ($rose(fl_we_n)) seen_rise <= 1'b1;
    end
  end

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n));

  p_we_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> !fl_cs_n);

  p_we_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out) && fl_dq_oe));

  p_we_rise_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_dq_out)));

  p_we_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> (low_cnt == 16'(T_WP)));

  p_we_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fl_we_n) && seen_rise) |-> (high_cnt >= 16'(T_WPH)));

  p_oe_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_oe_n) |-> ($stable(fl_addr) && !fl_cs_n));

  p_no_drive_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> !fl_dq_oe);

  p_ready_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  p_flags_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_err || op_timeout) |-> op_done);

  p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_err && op_timeout));

endmodule

bind flash_op_seq flash_op_seq_chk #(.AW(AW), .DW(DW), .T_WP(T_WP), .T_WPH(T_WPH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .op_done(op_done), .op_err(op_err), .op_timeout(op_timeout),
  .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
  .fl_cs_n(fl_cs_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
);

// File: tb/sim_flash_op_seq.sv
`timescale 1ns/1ps
module sim_flash_op_seq;

  localparam int AW = 21, DW = 16;
  localparam int T_AS = 1, T_WP = 3, T_WPH = 2, T_ASO = 1, T_RD = 2, T_OEH = 2;
  localparam int TMO_PROG = 300, TMO_SERASE = 600, TMO_CERASE = 900;
  localparam real PER = 5.0;

  typedef struct packed {
    logic [1:0]  op;
    logic [20:0] addr;
    logic [15:0] data;
    logic [15:0] busy;
    logic        bad;
    logic        exp_err;
    logic        exp_tmo;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{2'b00, 21'h01234, 16'hBEEF, 16'd3,     1'b0, 1'b0, 1'b0},
    '{2'b00, 21'h1FFFF, 16'h0000, 16'd0,     1'b0, 1'b0, 1'b0},
    '{2'b00, 21'h00ABC, 16'h5A5A, 16'd2,     1'b1, 1'b1, 1'b0},
    '{2'b01, 21'h08000, 16'h1234, 16'd5,     1'b1, 1'b0, 1'b0},
    '{2'b10, 21'h00333, 16'h0000, 16'd7,     1'b0, 1'b0, 1'b0},
    '{2'b11, 21'h10000, 16'h0000, 16'd2,     1'b0, 1'b0, 1'b0},
    '{2'b00, 21'h00040, 16'h00FF, 16'd60000, 1'b0, 1'b0, 1'b1},
    '{2'b01, 21'h18000, 16'h0000, 16'd60000, 1'b0, 1'b0, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic cmd_ready, op_done, op_err, op_timeout;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_dq_out, fl_dq_in;
  logic fl_dq_oe, fl_cs_n, fl_we_n, fl_oe_n;

  always #(PER/2) clk = ~clk;

  flash_op_seq #(
    .AW(AW), .DW(DW), .T_AS(T_AS), .T_WP(T_WP), .T_WPH(T_WPH), .T_ASO(T_ASO),
    .T_RD(T_RD), .T_OEH(T_OEH), .TMO_PROG(TMO_PROG), .TMO_SERASE(TMO_SERASE),
    .TMO_CERASE(TMO_CERASE)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .op_done(op_done), .op_err(op_err), .op_timeout(op_timeout),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_in(fl_dq_in),
    .fl_dq_oe(fl_dq_oe), .fl_cs_n(fl_cs_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

  // ---------------- flash model ----------------
  int busy_left = 0;
  logic tog = 1'b0;
  logic [15:0] mem_word = '1;
  int nw = 0, nrd = 0, rd_bad_addr = 0, oe_clash = 0;
  logic [20:0] exp_rd_addr = '0;
  logic [20:0] wa [16];
  logic [15:0] wd [16];
  realtime t_fall = 0, t_rise = 0, min_low = 1.0e9, min_gap = 1.0e9;
  bit have_rise = 0;

  assign fl_dq_in = (busy_left > 0) ? {9'b0, tog, 6'b0} : mem_word;

  always @(negedge fl_we_n) if (rst_n) begin
    if (have_rise && ($realtime - t_rise) < min_gap) min_gap = $realtime - t_rise;
    t_fall = $realtime;
  end

  always @(posedge fl_we_n) if (rst_n) begin
    if (($realtime - t_fall) < min_low) min_low = $realtime - t_fall;
    t_rise = $realtime;
    have_rise = 1;
    if (nw < 16) begin wa[nw] = fl_addr; wd[nw] = fl_dq_out; end
    nw++;
  end

  always @(posedge fl_oe_n) if (rst_n) begin
    nrd++;
    if (fl_addr != exp_rd_addr) rd_bad_addr++;
    if (busy_left > 0) begin busy_left--; tog = ~tog; end
  end

  always @(negedge clk) if (rst_n && !fl_oe_n && fl_dq_oe) oe_clash++;

  // ---------------- checking ----------------
  int errors = 0, checks = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void exp_wr(input logic [1:0] op, input int i, input logic [20:0] a,
                                 input logic [15:0] d, output logic [20:0] ea, output logic [15:0] ed);
    ea = 21'h555; ed = 16'h00AA;
    case (i)
      1, 4: begin ea = 21'h2AA; ed = 16'h0055; end
      2: ed = (op == 2'b00) ? 16'h00A0 : 16'h0080;
      3: if (op == 2'b00) begin ea = a; ed = d; end
      5: if (op == 2'b01) begin ea = a; ed = 16'h0030; end else ed = 16'h0010;
      default: ;
    endcase
  endfunction

  task automatic run_vec(input vec_t v, input string tag, input bit hold_valid);
    int nexp, polls, c;
    bit got;
    logic e, t;
    logic [20:0] ea;
    logic [15:0] ed;
    string rq;
    busy_left = int'(v.busy); tog = 1'b0;
    mem_word = (v.op == 2'b00) ? (v.bad ? ~v.data : v.data) : 16'hFFFF;
    nw = 0; nrd = 0; rd_bad_addr = 0; exp_rd_addr = v.addr;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = v.op; cmd_addr = v.addr; cmd_data = v.data;
    @(negedge clk);
    if (!hold_valid) cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R9", {tag, " ready low after accept"}, 32'(cmd_ready), 0);
    got = 0; c = 0; e = 0; t = 0;
    while (!got && c < 5000) begin
      @(negedge clk); c++;
      if (hold_valid && c == 10)
        chk(cmd_ready == 1'b0, "R9", {tag, " ready held low with valid"}, 32'(cmd_ready), 0);
      if (op_done) begin got = 1; e = op_err; t = op_timeout; cmd_valid = 1'b0; end
    end
    chk(got, "R6", {tag, " done seen"}, 32'(got), 1);
    chk(e == v.exp_err, "R7", {tag, " error flag"}, 32'(e), 32'(v.exp_err));
    chk(t == v.exp_tmo, "R8", {tag, " timeout flag"}, 32'(t), 32'(v.exp_tmo));
    chk(cmd_ready == 1'b1, "R9", {tag, " ready back with done"}, 32'(cmd_ready), 1);
    nexp = (v.op == 2'b00) ? 4 : 6;
    rq = (v.op == 2'b00) ? "R1" : (v.op == 2'b01) ? "R2" : "R3";
    chk(nw == nexp, rq, {tag, " write count"}, 32'(nw), 32'(nexp));
    for (int i = 0; i < nexp && i < nw; i++) begin
      exp_wr(v.op, i, v.addr, v.data, ea, ed);
      chk(wa[i] == ea && wd[i] == ed, rq, {tag, " write address/data"},
          {wa[i][15:0], wd[i]}, {ea[15:0], ed});
    end
    chk(rd_bad_addr == 0, "R5", {tag, " reads at request address"}, 32'(rd_bad_addr), 0);
    if (v.exp_tmo) begin
      chk(c > TMO_PROG, "R8", {tag, " timeout not early"}, 32'(c), TMO_PROG);
    end else begin
      if (v.busy == 0) polls = 2;
      else polls = (mem_word[6] == ((int'(v.busy) - 1) % 2 == 1)) ? int'(v.busy) + 1 : int'(v.busy) + 2;
      polls = polls + ((v.op == 2'b00) ? 1 : 0);
      chk(nrd == polls, "R6", {tag, " read count"}, 32'(nrd), 32'(polls));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_ready === 1'b1 && fl_cs_n === 1'b1 && fl_we_n === 1'b1 && fl_oe_n === 1'b1,
        "R10", "strobes idle in reset", {28'b0, cmd_ready, fl_cs_n, fl_we_n, fl_oe_n}, 32'hF);
    chk(fl_dq_oe === 1'b0 && op_done === 1'b0, "R10", "bus undriven in reset",
        {30'b0, fl_dq_oe, op_done}, 0);
    rst_n = 1'b1;
    for (int k = 0; k < NV; k++) run_vec(VEC[k], $sformatf("vec%0d", k), 1'b0);

    // reset in the middle of a program (R10)
    busy_left = 60000; tog = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b00; cmd_addr = 21'h00777; cmd_data = 16'h1111;
    @(negedge clk); cmd_valid = 1'b0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(fl_cs_n && fl_we_n && fl_oe_n && !fl_dq_oe && cmd_ready && !op_done,
        "R10", "mid-op reset idles bus",
        {26'b0, fl_cs_n, fl_we_n, fl_oe_n, fl_dq_oe, cmd_ready, op_done}, 32'h3A);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    run_vec(VEC[0], "after_reset_R10", 1'b0);

    // valid held high through an operation (R9)
    run_vec(VEC[3], "held_valid", 1'b1);

    chk(oe_clash == 0, "R11", "no drive while reading", 32'(oe_clash), 0);
    chk(min_low >= T_WP * PER - 0.01, "R4", "write strobe width ns", 32'(int'(min_low)), 32'(T_WP * 5));
    chk(min_gap >= T_WPH * PER - 0.01, "R4", "write strobe gap ns", 32'(int'(min_gap)), 32'(T_WPH * 5));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule